// File: doc/BRIEF.md
# Serially Configured Look-Up Table Logic Cell

This block is one programmable logic cell. A 4-input look-up table holds one stored bit per input combination, so the cell computes any 4-input boolean function: the output is the stored bit that the four inputs address. A mode bit chooses how that bit reaches the output. It can go straight through as a combinational path, or it can pass through a register that samples on the rising clock edge.

All 17 configuration bits sit in one serial shift chain: 16 table entries plus the mode bit. While `cfg_en_i` is high the chain moves one bit per clock. `cfg_i` enters at one end and `cfg_o` leaves at the other. Cells can therefore be wired in series, and 17·N bits configure N cells. The configuration can be reloaded as often as required.

The stream is sent in this order: mode bit first, then table entry 15, then the remaining entries down to entry 0. After 17 shifts, entry 0 is the bit nearest `cfg_i` and the mode bit is the bit nearest `cfg_o`. The reset clears only the output register and leaves the configuration untouched.

Top module: `lut_cell`

## Requirements
- R1: With mode bit 0 (combinational), `out_o` equals table entry `in_i` in the same cycle. This holds even while the chain is shifting, in which case the output follows the current chain contents.
- R2: With mode bit 1 (registered) and `cfg_en_i` low at a rising edge, `out_o` after that edge equals the table entry that `in_i` addressed before the edge. This gives exactly one cycle of latency.
- R3: The chain shifts one position per rising edge only while `cfg_en_i` is high. While `cfg_en_i` is low, the configuration and `cfg_o` do not change, whatever `cfg_i` does.
- R4: The serial order is mode bit first, then entries 15 down to 0. After 17 shifts, entry k is selected by `in_i == k`, and mode 1 selects the registered path.
- R5: `cfg_o` is the last chain bit. While shifting, it presents each bit 17 clocks after that bit entered on `cfg_i`, which allows cells to be daisy-chained.
- R6: While `cfg_en_i` is high, the output register holds its value.
- R7: `rst_ni` low clears the output register to 0 asynchronously. It leaves every configuration bit unchanged.
- R8: Loading a new stream fully replaces the previous function and mode, any number of times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_i | input | 1 | Serial configuration input |
| cfg_o | output | 1 | Serial configuration output, last chain bit |
| in_i | input | 4 | Look-up table address inputs |
| out_o | output | 1 | Cell output, combinational or registered |

## Verification
The configuration chain has no reset, so its contents are unknown until 17 bits have been shifted in. The properties on the table paths and on chain stability therefore apply only once the chain and `in_i` are known.

The register-hold property also assumes that the output register never captures while the chain is still unknown. The stimulus respects this by holding reset through the first complete load. Inputs change only between clock edges, so the registered path always samples a settled address.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int unsigned LUT_K = 4;
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
  parameter int unsigned LEN = 17
) (
  input  logic           clk_i,
  input  logic           cfg_en_i,
  input  logic           cfg_i,
  output logic [LEN-1:0] chain_o
);
  logic [LEN-1:0] chain_q;

  // no reset: configuration survives rst_ni
  always_ff @(posedge clk_i) begin
    if (cfg_en_i) chain_q <= {chain_q[LEN-2:0], cfg_i};
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/lut_read.sv
module lut_read #(
  parameter int unsigned K = 4,
  localparam int unsigned N = 2**K
) (
  input  logic [N-1:0] table_i,
  input  logic [K-1:0] addr_i,
  output logic         val_o
);
  // heap-ordered mux tree: nodes 0..N-2 internal, N-1..2N-2 leaves
  logic node [2*N-1];

  for (genvar l = 0; l < N; l++) begin : g_leaf
    assign node[N-1+l] = table_i[l];
  end

  for (genvar i = 0; i < N-1; i++) begin : g_node
    localparam int unsigned D = $clog2(i+2) - 1;
    assign node[i] = addr_i[K-1-D] ? node[2*i+2] : node[2*i+1];
  end

  assign val_o = node[0];
endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage
  import lut_cell_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cfg_en_i,
  input  out_mode_e mode_i,
  input  logic      lut_val_i,
  output logic      reg_q_o,
  output logic      out_o
);
  logic reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reg_q <= 1'b0;
    else if (!cfg_en_i) reg_q <= lut_val_i;
  end

  assign reg_q_o = reg_q;
  assign out_o   = (mode_i == OUT_REG) ? reg_q : lut_val_i;
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int unsigned K = LUT_K,
  localparam int unsigned N   = 2**K,
  localparam int unsigned LEN = N + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_en_i,
  input  logic         cfg_i,
  output logic         cfg_o,
  input  logic [K-1:0] in_i,
  output logic         out_o
);
  logic [LEN-1:0] chain_q;
  logic           lut_val;
  logic           reg_q;
  out_mode_e      mode;

  lut_cfg_chain #(.LEN(LEN)) chain_i (
    .clk_i    (clk_i),
    .cfg_en_i (cfg_en_i),
    .cfg_i    (cfg_i),
    .chain_o  (chain_q)
  );

  // mode bit is shifted first, so it ends at the far end
  assign mode  = out_mode_e'(chain_q[LEN-1]);
  assign cfg_o = chain_q[LEN-1];

  lut_read #(.K(K)) read_i (
    .table_i (chain_q[N-1:0]),
    .addr_i  (in_i),
    .val_o   (lut_val)
  );

  lut_out_stage out_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_en_i  (cfg_en_i),
    .mode_i    (mode),
    .lut_val_i (lut_val),
    .reg_q_o   (reg_q),
    .out_o     (out_o)
  );
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
  parameter int unsigned K = 4,
  localparam int unsigned N   = 2**K,
  localparam int unsigned LEN = N + 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_en_i,
  input logic           cfg_i,
  input logic           cfg_o,
  input logic [K-1:0]   in_i,
  input logic           out_o,
  input logic [LEN-1:0] chain_i,
  input logic           reg_i
);
  logic known;
  assign known = !$isunknown({chain_i, in_i});

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && known) |=> $stable(chain_i)) else $error("AST_CFG_FROZEN"); // R3

  AST_SHIFT_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && known) |=> cfg_o == $past(chain_i[LEN-2])) else $error("AST_SHIFT_OUT"); // R5

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && !$isunknown(reg_i)) |=> $stable(reg_i)) else $error("AST_REG_HOLD"); // R6

  AST_COMB_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (known && !chain_i[LEN-1]) |-> out_o == chain_i[in_i]) else $error("AST_COMB_OUT"); // R1

  AST_REG_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (known && !cfg_en_i && chain_i[LEN-1]) |=> out_o == $past(chain_i[in_i])) else $error("AST_REG_OUT"); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    (rst_ni === 1'b0) |-> reg_i == 1'b0) else $error("AST_RESET_CLEAR"); // R7
endmodule

bind lut_cell lut_cell_chk #(.K(K)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_en_i (cfg_en_i),
  .cfg_i    (cfg_i),
  .cfg_o    (cfg_o),
  .in_i     (in_i),
  .out_o    (out_o),
  .chain_i  (chain_q),
  .reg_i    (reg_q)
);

// File: tb/lut_cell_tb_top.sv
module lut_cell_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_en_i = 1'b0;
  logic       cfg_i = 1'b0;
  logic       cfg_o;
  logic [3:0] in_i = 4'd0;
  logic       out_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #5 clk_i = ~clk_i;

  lut_cell dut_i (.*);

  // behavioural model: queue of shifted bits, newest at index 0
  bit cq[$];
  bit mreg = 1'b0;
  bit mreg_ok = 1'b1;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      mreg = 1'b0; mreg_ok = 1'b1;
    end else if (!cfg_en_i) begin
      if (cq.size() == 17) mreg = cq[in_i];
      else mreg_ok = 1'b0;
    end
    if (cfg_en_i) begin
      cq.push_front(cfg_i);
      if (cq.size() > 17) void'(cq.pop_back());
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    cyc++;
    if (cq.size() == 17) begin
      chk("R5 cfg_o", cfg_o, cq[16]);
      if (!cq[16]) chk("R1 comb", out_o, cq[in_i]);
      else if (mreg_ok) chk(cfg_en_i ? "R6 hold" : "R2 reg", out_o, mreg);
    end
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic load(bit mode, bit [15:0] tbl);
    cfg_en_i = 1'b1;
    for (int b = 0; b < 17; b++) begin
      cfg_i = (b == 0) ? mode : tbl[16-b];
      step();
    end
    cfg_en_i = 1'b0;
  endtask

  initial begin
    bit [15:0] tbl;
    bit        old;
    step();
    // first load happens under reset so the register never sees an unknown chain
    load(1'b1, 16'hA5C3);
    chk("R7 reset state", out_o, 1'b0);
    chk("R4 mode bit at cfg_o", cfg_o, 1'b1);
    rst_ni = 1'b1;
    step();

    // R4: explicit ordering check in combinational mode
    tbl = 16'h8001;
    load(1'b0, tbl);
    in_i = 4'd0;  #1 chk("R4 entry0", out_o, 1'b1);
    in_i = 4'd1;  #1 chk("R4 entry1", out_o, 1'b0);
    in_i = 4'd15; #1 chk("R4 entry15", out_o, 1'b1);
    in_i = 4'd14; #1 chk("R4 entry14", out_o, 1'b0);
    step();

    // R3: chain frozen with enable low while cfg_i toggles
    old = cfg_o;
    for (int i = 0; i < 20; i++) begin
      cfg_i = ~cfg_i;
      step();
      chk("R3 frozen", cfg_o, old);
    end

    // R8/R1/R2: random functions in both modes, full input sweep
    for (int it = 0; it < 8; it++) begin
      bit m;
      m = it[0];
      tbl = 16'($urandom);
      load(m, tbl);
      for (int a = 0; a < 16; a++) begin
        in_i = 4'(a);
        #1;
        if (!m) chk("R8 comb reload", out_o, tbl[a]);
        step();
        if (m) chk("R8 reg reload", out_o, tbl[a]);
      end
    end

    // R2: one-cycle latency observed directly
    tbl = 16'h00FF;
    load(1'b1, tbl);
    in_i = 4'd3; step();
    chk("R2 settle", out_o, 1'b1);
    in_i = 4'd12; #1;
    chk("R2 no zero-latency", out_o, 1'b1);
    step();
    chk("R2 one cycle", out_o, 1'b0);

    // R7: reset mid-run clears register, configuration kept
    in_i = 4'd5; step();
    chk("R7 pre", out_o, 1'b1);
    rst_ni = 1'b0; #1;
    chk("R7 async clear", out_o, 1'b0);
    step();
    chk("R7 cfg kept", cfg_o, 1'b1);
    rst_ni = 1'b1; step();
    chk("R7 table kept", out_o, 1'b1);

    // R6: register holds through a reload in registered mode
    in_i = 4'd9; step();
    load(1'b1, 16'hFFFF);
    step();
    chk("R6 after load", out_o, 1'b1);
    repeat (3) step();
    finish_up();
  end
endmodule